// File: doc/BRIEF.md
# Wake-up Event and Signalling Controller

This block decides when a sleeping network controller should wake the system, and how it signals that. It takes the wake-mode configuration, the power-good input, the link status and a one-cycle pulse from an external magic-frame detector. It drives a remote-wake pin with programmable polarity, a power-management event (PME) output, an interrupt request, a wake-mode indicator and a bank of LEDs. A small set of sticky status bits records which wake events have occurred. Software clears these bits with write-one-to-clear strobes.

There are two configuration paths. The software path is held in registers that only the power-on reset clears, so its settings survive hardware and bus resets. The hardware remote-wake path is held in registers that the hardware reset clears. Those registers can be loaded by software or by an EEPROM load strobe. Both paths feed the same status bits.

While magic mode is on, the block asks the MAC datapath to stop traffic. Once the FIFOs are empty it reports that traffic is halted. It releases the datapath only after a magic frame has been seen and the mode has also been switched off, so no re-initialisation is needed.

All of the block's ports are plain control and status levels or pulses. No data stream passes through it, so there is no valid/ready handshake and no back-pressure.

Top module: `wake_event_ctrl`

## Requirements
- R1: After reset, the status bits read 0 and the outputs are inactive: PME, interrupt, wake indicator, hold and halted all read 0. The remote-wake pin equals the polarity bit, which resets to 0. Each LED reads the inverse of its polarity input.
- R2: The software configuration is unchanged by a hardware reset; only power-on reset clears it. The hardware configuration is cleared by a hardware reset. When the EEPROM load and the software write to the hardware configuration occur in the same cycle, the EEPROM data is stored.
- R3: The hardware configuration layout is: bit 0 link-change enable, bit 1 magic enable, bit 2 power-gated magic enable, bit 3 PME override, bit 4 remote-wake polarity. The software configuration layout is: bit 0 link-change enable, bit 1 magic enable, bit 2 power-gated magic enable, bit 3 pattern enable. Link-change mode is on when either link-change enable is set. While it is on, any edge of the link input sets status bit 0 and status bit 3 three clock edges later. While it is off, link edges have no effect.
- R4: The wake indicator is high when any of the following is true:
  - either direct magic enable is set;
  - either power-gated magic enable is set while the synchronised power-good is low.
  A change on the power-good input reaches the indicator after two clock edges.
- R5: A magic-detect pulse while magic mode is on sets, on the next edge, status bit 1 (detected), bit 2 (interrupt) and bit 3 (PME status). While magic mode is off, the pulse has no effect.
- R6: The remote-wake pin equals (status bit 0 OR status bit 1) XOR the polarity bit.
- R7: PME asserts when status bit 3 is set and the PME enable input is high. It also asserts when the PME override bit is set and status bit 0 or bit 1 is set.
- R8: With the pattern enable set, a pattern-match pulse sets only status bit 3. It never drives the remote-wake pin.
- R9: The interrupt output is high when status bit 2 is set and both the global and the magic interrupt enable inputs are high.
- R10: The magic-activity level is status bit 1 AND the LED's select input. An LED whose polarity input is 1 shows this level directly. An LED whose polarity input is 0 shows its inverse.
- R11: Status bits are sticky until their clear strobe is pulsed. A clear strobe and a new set on the same bit in the same cycle leave the bit set.
- R12: The hold output rises one edge after magic mode turns on. The halted output follows one edge after the FIFO-empty input is seen high while hold is asserted.
- R13: Hold and halted drop only when a magic frame has been detected and magic mode has also been turned off. They drop one edge after the second of these two conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| hrst_n | input | 1 | Hardware reset, active low, asynchronous |
| sw_cfg_we | input | 1 | Software configuration write strobe |
| sw_cfg_d | input | 4 | Software configuration data |
| hw_cfg_sw_we | input | 1 | Software write strobe for the hardware configuration |
| hw_cfg_sw_d | input | 5 | Software data for the hardware configuration |
| hw_cfg_ee_we | input | 1 | EEPROM load strobe for the hardware configuration |
| hw_cfg_ee_d | input | 5 | EEPROM data for the hardware configuration |
| pme_en | input | 1 | PME enable from power-management space |
| int_en | input | 1 | Global interrupt enable |
| mp_int_en | input | 1 | Magic interrupt enable |
| led_sel | input | LED_N | Per-LED magic-activity select |
| led_pol | input | LED_N | Per-LED polarity, 1 = active high |
| pg | input | 1 | Power-good, asynchronous |
| link | input | 1 | Link status, asynchronous |
| fifo_empty | input | 1 | MAC FIFOs drained |
| mp_det_in | input | 1 | Magic-frame detect pulse |
| pat_in | input | 1 | Pattern-match detect pulse |
| stat_clr | input | 4 | Write-one-to-clear strobes, one per status bit |
| stat | output | 4 | Sticky status: 0 link change, 1 magic detected, 2 magic interrupt, 3 PME status |
| rwu_pin | output | 1 | Remote-wake pin |
| pme_out | output | 1 | PME output |
| irq | output | 1 | Interrupt request |
| wum | output | 1 | Wake-mode indicator |
| led | output | LED_N | LED outputs |
| mac_hold | output | 1 | Request to the MAC to stop traffic |
| mac_idle | output | 1 | Traffic halted after drain |

## Verification
A status bit can receive a clear strobe and a new set event on the same clock edge. The bench provokes this by driving a magic-detect pulse and all four clear strobes in the same cycle while magic mode is on. The result is judged at the ports on the next edge, where the detected, interrupt and PME-status bits must read 1. A second meeting point is the resume condition. The magic frame arrives while the mode is still on, then the mode is switched off; the bench checks that hold stays high after the detection and falls only one edge after the disable.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int SW_CFG_W = 4;
  localparam int HW_CFG_W = 5;
  localparam int STAT_W   = 4;

  localparam int ST_LC  = 0;
  localparam int ST_MPD = 1;
  localparam int ST_MPI = 2;
  localparam int ST_PME = 3;

  typedef struct packed {
    logic pat;
    logic mpp;
    logic mp;
    logic lc;
  } sw_cfg_t;

  typedef struct packed {
    logic pol;
    logic ovr;
    logic mpp;
    logic mp;
    logic lc;
  } hw_cfg_t;

  typedef enum logic [1:0] {
    SUS_RUN   = 2'd0,
    SUS_DRAIN = 2'd1,
    SUS_HALT  = 2'd2
  } sus_state_e;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/wake_cfg.sv
module wake_cfg
  import wake_pkg::*;
(
  input  logic                clk,
  input  logic                por_n,
  input  logic                rst_hw_n,
  input  logic                sw_we,
  input  logic [SW_CFG_W-1:0] sw_d,
  input  logic                hw_sw_we,
  input  logic [HW_CFG_W-1:0] hw_sw_d,
  input  logic                hw_ee_we,
  input  logic [HW_CFG_W-1:0] hw_ee_d,
  output sw_cfg_t             sw_cfg,
  output hw_cfg_t             hw_cfg
);
  // software path: survives hardware reset
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     sw_cfg <= '0;
    else if (sw_we) sw_cfg <= sw_cfg_t'(sw_d);
  end

  // hardware path: EEPROM load outranks a software write
  always_ff @(posedge clk or negedge rst_hw_n) begin
    if (!rst_hw_n)     hw_cfg <= '0;
    else if (hw_ee_we) hw_cfg <= hw_cfg_t'(hw_ee_d);
    else if (hw_sw_we) hw_cfg <= hw_cfg_t'(hw_sw_d);
  end
endmodule

// File: rtl/wake_status.sv
module wake_status #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= set[i] | (q[i] & ~clr[i]);
    end
  end
endmodule

// File: rtl/wake_suspend.sv
module wake_suspend
  import wake_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode,
  input  logic mp_evt,
  input  logic fifo_empty,
  output logic hold,
  output logic idle
);
  sus_state_e st, st_nx;
  logic seen, seen_nx;

  always_comb begin
    seen_nx = seen | mp_evt;
    st_nx   = st;
    unique case (st)
      SUS_RUN:   if (mode) st_nx = SUS_DRAIN;
      SUS_DRAIN: if (seen_nx && !mode) st_nx = SUS_RUN;
                 else if (fifo_empty)  st_nx = SUS_HALT;
      SUS_HALT:  if (seen_nx && !mode) st_nx = SUS_RUN;
      default:   st_nx = SUS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= SUS_RUN;
      seen <= 1'b0;
    end else begin
      st   <= st_nx;
      seen <= (st_nx == SUS_RUN) ? 1'b0 : seen_nx;
    end
  end

  assign hold = (st != SUS_RUN);
  assign idle = (st == SUS_HALT);
endmodule

// File: rtl/wake_led.sv
module wake_led #(
  parameter int N = 4
) (
  input  logic         act,
  input  logic [N-1:0] sel,
  input  logic [N-1:0] pol,
  output logic [N-1:0] led
);
  for (genvar i = 0; i < N; i++) begin : g_led
    assign led[i] = (act & sel[i]) ^ ~pol[i];
  end
endmodule

// File: rtl/wake_event_ctrl.sv
module wake_event_ctrl
  import wake_pkg::*;
#(
  parameter int LED_N       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                hrst_n,
  input  logic                sw_cfg_we,
  input  logic [SW_CFG_W-1:0] sw_cfg_d,
  input  logic                hw_cfg_sw_we,
  input  logic [HW_CFG_W-1:0] hw_cfg_sw_d,
  input  logic                hw_cfg_ee_we,
  input  logic [HW_CFG_W-1:0] hw_cfg_ee_d,
  input  logic                pme_en,
  input  logic                int_en,
  input  logic                mp_int_en,
  input  logic [LED_N-1:0]    led_sel,
  input  logic [LED_N-1:0]    led_pol,
  input  logic                pg,
  input  logic                link,
  input  logic                fifo_empty,
  input  logic                mp_det_in,
  input  logic                pat_in,
  input  logic [STAT_W-1:0]   stat_clr,
  output logic [STAT_W-1:0]   stat,
  output logic                rwu_pin,
  output logic                pme_out,
  output logic                irq,
  output logic                wum,
  output logic [LED_N-1:0]    led,
  output logic                mac_hold,
  output logic                mac_idle
);
  localparam int SYNC_W = 2;

  logic    rst_hw_n;
  sw_cfg_t sw_cfg;
  hw_cfg_t hw_cfg;
  logic [SYNC_W-1:0] sync_q;
  logic    pg_s, link_s, link_q;
  logic    lc_mode, mp_mode, link_chg;
  logic    lc_evt, mp_evt, pat_evt, wake_lvl;
  logic [STAT_W-1:0] stat_set;

  assign rst_hw_n = por_n & hrst_n;

  wake_cfg u_cfg (
    .clk      (clk),
    .por_n    (por_n),
    .rst_hw_n (rst_hw_n),
    .sw_we    (sw_cfg_we),
    .sw_d     (sw_cfg_d),
    .hw_sw_we (hw_cfg_sw_we),
    .hw_sw_d  (hw_cfg_sw_d),
    .hw_ee_we (hw_cfg_ee_we),
    .hw_ee_d  (hw_cfg_ee_d),
    .sw_cfg   (sw_cfg),
    .hw_cfg   (hw_cfg)
  );

  wake_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_hw_n),
    .d     ({pg, link}),
    .q     (sync_q)
  );
  assign {pg_s, link_s} = sync_q;

  always_ff @(posedge clk or negedge rst_hw_n) begin
    if (!rst_hw_n) link_q <= 1'b0;
    else           link_q <= link_s;
  end
  assign link_chg = link_s ^ link_q;

  assign lc_mode = sw_cfg.lc | hw_cfg.lc;
  assign mp_mode = sw_cfg.mp | hw_cfg.mp | ((sw_cfg.mpp | hw_cfg.mpp) & ~pg_s);

  assign lc_evt  = lc_mode & link_chg;
  assign mp_evt  = mp_mode & mp_det_in;
  assign pat_evt = sw_cfg.pat & pat_in;

  always_comb begin
    stat_set         = '0;
    stat_set[ST_LC]  = lc_evt;
    stat_set[ST_MPD] = mp_evt;
    stat_set[ST_MPI] = mp_evt;
    stat_set[ST_PME] = lc_evt | mp_evt | pat_evt;
  end

  wake_status #(.W(STAT_W)) u_stat (
    .clk   (clk),
    .rst_n (rst_hw_n),
    .set   (stat_set),
    .clr   (stat_clr),
    .q     (stat)
  );

  // pattern match feeds PME status only, never the remote-wake level
  assign wake_lvl = stat[ST_LC] | stat[ST_MPD];
  assign rwu_pin  = wake_lvl ^ hw_cfg.pol;
  assign pme_out  = (stat[ST_PME] & pme_en) | (wake_lvl & hw_cfg.ovr);
  assign irq      = stat[ST_MPI] & int_en & mp_int_en;
  assign wum      = mp_mode;

  wake_led #(.N(LED_N)) u_led (
    .act (stat[ST_MPD]),
    .sel (led_sel),
    .pol (led_pol),
    .led (led)
  );

  wake_suspend u_sus (
    .clk        (clk),
    .rst_n      (rst_hw_n),
    .mode       (mp_mode),
    .mp_evt     (mp_evt),
    .fifo_empty (fifo_empty),
    .hold       (mac_hold),
    .idle       (mac_idle)
  );
endmodule

// File: rtl/wake_event_ctrl_chk.sv
module wake_event_ctrl_chk
  import wake_pkg::*;
(
  input logic              clk,
  input logic              por_n,
  input logic              hrst_n,
  input logic              mp_det_in,
  input logic [STAT_W-1:0] stat_clr,
  input logic [STAT_W-1:0] stat,
  input logic              irq,
  input logic              wum,
  input logic              mac_hold,
  input logic              mac_idle
);
  logic rst_ok;
  assign rst_ok = por_n & hrst_n;

  for (genvar i = 0; i < STAT_W; i++) begin : g_sticky
    assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_ok)
      (stat[i] && !stat_clr[i]) |=> stat[i]);
  end

  assert_detect_sets_pme_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(stat[ST_MPD]) |-> stat[ST_PME]);

  assert_detect_ignored_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    (mp_det_in && !wum && !stat[ST_MPD]) |=> !stat[ST_MPD]);

  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    irq |-> stat[ST_MPI]);

  assert_idle_in_hold_R12: assert property (@(posedge clk) disable iff (!rst_ok)
    mac_idle |-> mac_hold);

  assert_resume_mode_off_R13: assert property (@(posedge clk) disable iff (!rst_ok)
    $fell(mac_hold) |-> !wum);
endmodule

bind wake_event_ctrl wake_event_ctrl_chk u_chk (
  .clk       (clk),
  .por_n     (por_n),
  .hrst_n    (hrst_n),
  .mp_det_in (mp_det_in),
  .stat_clr  (stat_clr),
  .stat      (stat),
  .irq       (irq),
  .wum       (wum),
  .mac_hold  (mac_hold),
  .mac_idle  (mac_idle)
);

// File: tb/wake_event_ctrl_test.sv
`timescale 1ns/1ps
module wake_event_ctrl_test;
  localparam int LED_N = 4;
  localparam int WD_LIMIT = 5000;

  localparam logic [13:0] M_STAT = 14'h000F;
  localparam logic [13:0] M_RWU  = 14'h0010;
  localparam logic [13:0] M_PME  = 14'h0020;
  localparam logic [13:0] M_IRQ  = 14'h0040;
  localparam logic [13:0] M_WUM  = 14'h0080;
  localparam logic [13:0] M_LED  = 14'h0F00;
  localparam logic [13:0] M_HOLD = 14'h1000;
  localparam logic [13:0] M_IDLE = 14'h2000;
  localparam logic [13:0] M_ALL  = 14'h3FFF;

  logic clk = 0;
  logic por_n = 0, hrst_n = 0;
  logic sw_cfg_we = 0;
  logic [3:0] sw_cfg_d = 0;
  logic hw_cfg_sw_we = 0, hw_cfg_ee_we = 0;
  logic [4:0] hw_cfg_sw_d = 0, hw_cfg_ee_d = 0;
  logic pme_en = 0, int_en = 0, mp_int_en = 0;
  logic [LED_N-1:0] led_sel = 0, led_pol = 4'b0101;
  logic pg = 0, link = 0, fifo_empty = 1, mp_det_in = 0, pat_in = 0;
  logic [3:0] stat_clr = 0;
  logic [3:0] stat;
  logic rwu_pin, pme_out, irq, wum, mac_hold, mac_idle;
  logic [LED_N-1:0] led;
  logic [13:0] obs;

  int cyc = 0, total = 0, bad = 0;

  typedef struct {
    int          due;
    logic [13:0] mask;
    logic [13:0] val;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wake_event_ctrl #(.LED_N(LED_N)) uut (
    .clk(clk), .por_n(por_n), .hrst_n(hrst_n),
    .sw_cfg_we(sw_cfg_we), .sw_cfg_d(sw_cfg_d),
    .hw_cfg_sw_we(hw_cfg_sw_we), .hw_cfg_sw_d(hw_cfg_sw_d),
    .hw_cfg_ee_we(hw_cfg_ee_we), .hw_cfg_ee_d(hw_cfg_ee_d),
    .pme_en(pme_en), .int_en(int_en), .mp_int_en(mp_int_en),
    .led_sel(led_sel), .led_pol(led_pol), .pg(pg), .link(link),
    .fifo_empty(fifo_empty), .mp_det_in(mp_det_in), .pat_in(pat_in),
    .stat_clr(stat_clr), .stat(stat), .rwu_pin(rwu_pin), .pme_out(pme_out),
    .irq(irq), .wum(wum), .led(led), .mac_hold(mac_hold), .mac_idle(mac_idle)
  );

  assign obs = {mac_idle, mac_hold, led, wum, irq, pme_out, rwu_pin, stat};

  // driver side: push an expectation due dly edges from now
  task automatic expect_at(int dly, logic [13:0] mask, logic [13:0] val, string tag);
    exp_t e;
    e.due = cyc + dly; e.mask = mask; e.val = val; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // monitor side: compare due items at the falling edge
  always @(negedge clk) begin
    exp_t keep[$];
    keep = {};
    foreach (sb[i]) begin
      if (sb[i].due <= cyc) begin
        total++;
        if (sb[i].due < cyc || (obs & sb[i].mask) != (sb[i].val & sb[i].mask)) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h mask=%h cyc=%0d",
                   sb[i].tag, obs & sb[i].mask, sb[i].val & sb[i].mask, sb[i].mask, cyc);
        end
      end else keep.push_back(sb[i]);
    end
    sb = keep;
  end

  always @(posedge clk) begin
    if (cyc >= WD_LIMIT) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    por_n = 1; hrst_n = 1;
    expect_at(1, M_ALL, 14'h0A00, "R1 reset state");
    step(2);

    // magic mode by software direct enable, drain and halt
    sw_cfg_we = 1; sw_cfg_d = 4'b0010;
    expect_at(1, M_WUM, M_WUM, "R4 direct enable");
    expect_at(2, M_HOLD | M_IDLE, M_HOLD, "R12 hold rises");
    expect_at(3, M_HOLD | M_IDLE, M_HOLD | M_IDLE, "R12 halted after drain");
    step(1); sw_cfg_we = 0; step(4);

    // hardware reset keeps software config
    hrst_n = 0; step(1); hrst_n = 1;
    expect_at(1, M_WUM, M_WUM, "R2 sw cfg survives");
    step(4);

    // magic detect while mode on
    mp_det_in = 1;
    expect_at(1, M_STAT | M_RWU | M_PME | M_IRQ, 14'h001E, "R5 detect sets status");
    expect_at(3, M_IDLE, M_IDLE, "R13 no resume while mode on");
    step(1); mp_det_in = 0; step(3);

    sw_cfg_we = 1; sw_cfg_d = 4'b0000;
    expect_at(1, M_WUM, 14'h0000, "R4 disable");
    expect_at(2, M_HOLD | M_IDLE, 14'h0000, "R13 resume");
    step(1); sw_cfg_we = 0; step(2);

    int_en = 1; mp_int_en = 1; pme_en = 1; led_sel = 4'b0011;
    expect_at(1, M_IRQ, M_IRQ, "R9 irq");
    expect_at(1, M_PME, M_PME, "R7 pme enable");
    expect_at(1, M_LED, 14'h0900, "R10 led lanes");
    step(2);

    stat_clr = 4'hF;
    expect_at(1, M_STAT | M_RWU | M_PME | M_IRQ | M_LED, 14'h0A00, "R11 clear");
    step(1); stat_clr = 0; step(1);

    mp_det_in = 1;
    expect_at(1, M_STAT | M_HOLD, 14'h0000, "R5 ignored when off");
    step(1); mp_det_in = 0; step(1);

    // EEPROM load outranks software write
    hw_cfg_ee_we = 1; hw_cfg_ee_d = 5'b00100; hw_cfg_sw_we = 1; hw_cfg_sw_d = 5'b00000;
    expect_at(1, M_WUM, M_WUM, "R2 eeprom priority, R4 power-gated");
    step(1); hw_cfg_ee_we = 0; hw_cfg_sw_we = 0;
    pg = 1;
    expect_at(1, M_WUM, M_WUM, "R4 pg not yet synced");
    expect_at(2, M_WUM, 14'h0000, "R4 pg disables");
    step(3);
    hw_cfg_sw_we = 1; hw_cfg_sw_d = 5'b00010;
    expect_at(1, M_WUM, M_WUM, "R4 hw direct enable");
    step(1); hw_cfg_sw_we = 0; step(1);
    hrst_n = 0; step(1); hrst_n = 1;
    expect_at(1, M_WUM, 14'h0000, "R2 hw cfg cleared");
    step(3);

    // link change
    link = 1;
    expect_at(3, M_STAT, 14'h0000, "R3 no mode no effect");
    step(5);
    sw_cfg_we = 1; sw_cfg_d = 4'b0001; step(1); sw_cfg_we = 0;
    link = 0;
    expect_at(2, M_STAT, 14'h0000, "R3 not before sync");
    expect_at(3, M_STAT | M_RWU | M_PME, 14'h0039, "R3 link change sets");
    step(5);
    stat_clr = 4'hF; step(1); stat_clr = 0; step(1);
    sw_cfg_we = 1; sw_cfg_d = 4'b0000;
    hw_cfg_sw_we = 1; hw_cfg_sw_d = 5'b10001;
    expect_at(1, M_RWU, M_RWU, "R6 polarity idle");
    step(1); sw_cfg_we = 0; hw_cfg_sw_we = 0;
    link = 1;
    expect_at(3, M_STAT | M_RWU, 14'h0009, "R6 polarity active, R3 hw enable");
    step(5);
    stat_clr = 4'hF; step(1); stat_clr = 0; step(1);

    // override routing
    pme_en = 0;
    hw_cfg_sw_we = 1; hw_cfg_sw_d = 5'b01001;
    step(1); hw_cfg_sw_we = 0;
    link = 0;
    expect_at(3, M_STAT | M_PME | M_RWU, 14'h0039, "R7 override");
    step(5);
    stat_clr = 4'hF; step(1); stat_clr = 0; step(1);

    // pattern match
    sw_cfg_we = 1; sw_cfg_d = 4'b1000; step(1); sw_cfg_we = 0;
    pat_in = 1;
    expect_at(1, M_STAT | M_RWU | M_PME, 14'h0008, "R8 pattern only pme status");
    step(1); pat_in = 0; pme_en = 1;
    expect_at(1, M_PME, M_PME, "R7 pme from pattern");
    step(2);

    // clear and set in the same cycle
    stat_clr = 4'hF; step(1); stat_clr = 0;
    sw_cfg_we = 1; sw_cfg_d = 4'b0010; step(1); sw_cfg_we = 0; step(3);
    mp_det_in = 1; stat_clr = 4'hF;
    expect_at(1, M_STAT, 14'h000E, "R11 set wins");
    step(1); mp_det_in = 0; stat_clr = 0;
    step(4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule